// File: doc/BRIEF.md
# Staggered Sample Strobe Generator

This block produces the phase-spread sample strobes that align six groups of colour video channels ahead of a display panel that latches eighteen dots at once. Each group is a red, green and blue triple; one strobe per group samples all three of its channels together. The strobes are spaced evenly across one horizontal shift-clock period. Their firing order follows the panel's horizontal scan direction.

The block runs on a master clock. A full strobe period is `NUM_GRP * GAP` master cycles long, which is 12 with the defaults. A qualifier marks the active part of each line. On the rising edge of that qualifier, the block restarts its phase and takes a new copy of the scan-direction bit. While the line is active, one strobe fires every `GAP` cycles. A half-period reference clock `hck_o` comes out alongside the strobes, so the downstream horizontal shift clock can be aligned with the same phase count.

Top module: `stagger_strobe_gen`

## Requirements
- R1: While `rst_ni` is low, `stb_o` and `hck_o` are all zero, whatever the inputs do.
- R2: At most one bit of `stb_o` is high in any cycle, and each strobe lasts exactly one master cycle.
- R3: With the direction latched low (normal scan), `stb_o[g]` fires at phase `2*g` of each 12-cycle period, so bit 0 fires first and bit 5 fires last.
- R4: With the direction latched high (reverse scan), `stb_o[g]` fires at phase `2*(5-g)`, so bit 5 fires first and bit 0 fires last.
- R5: During an active line, strobes repeat with a period of 12 master cycles, and successive strobes are exactly 2 cycles apart.
- R6: In any cycle that follows a clock edge at which `line_active_i` was sampled low, `stb_o` and `hck_o` are zero.
- R7: The phase restarts at each line start. In the cycle after the edge that first samples `line_active_i` high, the phase is 0 and the first strobe of the order is output.
- R8: `scan_rev_i` is sampled only at the line-start edge. A change in the middle of a line has no effect until the next line start.
- R9: During an active line, `hck_o` is high for phases 0 to 5 and low for phases 6 to 11 of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, 12x the horizontal shift-clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_active_i | input | 1 | High during the active part of a line; its rising edge starts a line |
| scan_rev_i | input | 1 | Horizontal scan direction: 0 normal, 1 reverse; sampled at line start |
| stb_o | output | NUM_GRP | One-cycle sample strobe per channel group, bit g for group g+1 |
| hck_o | output | 1 | Shift-clock phase reference, high for the first half of each period |

## Verification
A phase counter that is off by one moves every strobe and the edges of `hck_o` by one master cycle. This shows up within the first two cycles of a line. A counter that fails to wrap or to restart gives a missing or misplaced strobe within one 12-cycle period. A direction latch that follows `scan_rev_i` in the middle of a line reverses the strobe order at the next strobe, no more than 2 cycles after the toggle. Lines of different lengths are swept with both directions and with gaps as short as one cycle, and every output is compared in every cycle.

// File: rtl/stagger_strobe_pkg.sv
package stagger_strobe_pkg;
  parameter int unsigned DEF_NUM_GRP = 6;
  parameter int unsigned DEF_GAP     = 2;
endpackage

// File: rtl/stb_phase_ctr.sv
module stb_phase_ctr #(
  parameter int unsigned PERIOD = 12,
  parameter int unsigned PH_W   = $clog2(PERIOD)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            line_active_i,
  input  logic            scan_rev_i,
  output logic [PH_W-1:0] phase_o,
  output logic            run_o,
  output logic            rev_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);

  logic [PH_W-1:0] ph_q;
  logic            run_q;
  logic            rev_q;
  logic            line_start;

  assign line_start = line_active_i & ~run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      run_q <= 1'b0;
      rev_q <= 1'b0;
    end else begin
      run_q <= line_active_i;
      if (line_start) rev_q <= scan_rev_i;
      if (!line_active_i || !run_q) ph_q <= '0;
      else if (ph_q == PH_LAST)     ph_q <= '0;
      else                          ph_q <= ph_q + 1'b1;
    end
  end

  assign phase_o = ph_q;
  assign run_o   = run_q;
  assign rev_o   = rev_q;

  p_ph_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= PH_LAST);
  p_ph_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && line_active_i && ph_q != PH_LAST) |=> ph_q == $past(ph_q) + 1'b1);
  p_dir_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q)) |-> $stable(rev_q));
  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> ph_q == '0);
endmodule

// File: rtl/stb_decode.sv
module stb_decode #(
  parameter int unsigned NUM_GRP = 6,
  parameter int unsigned GAP     = 2,
  parameter int unsigned PERIOD  = NUM_GRP * GAP,
  parameter int unsigned PH_W    = $clog2(PERIOD)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PH_W-1:0]    phase_i,
  input  logic               run_i,
  input  logic               rev_i,
  output logic [NUM_GRP-1:0] stb_o,
  output logic               hck_o
);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(PERIOD / 2);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam logic [PH_W-1:0] PH_FWD = PH_W'(g * GAP);
    localparam logic [PH_W-1:0] PH_REV = PH_W'((NUM_GRP - 1 - g) * GAP);
    assign stb_o[g] = run_i && (phase_i == (rev_i ? PH_REV : PH_FWD));
  end

  assign hck_o = run_i && (phase_i < PH_HALF);

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb_o));
  p_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|stb_o) |=> !(|stb_o));
endmodule

// File: rtl/stagger_strobe_gen.sv
module stagger_strobe_gen
  import stagger_strobe_pkg::*;
#(
  parameter int unsigned NUM_GRP = DEF_NUM_GRP,
  parameter int unsigned GAP     = DEF_GAP
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_active_i,
  input  logic               scan_rev_i,
  output logic [NUM_GRP-1:0] stb_o,
  output logic               hck_o
);
  localparam int unsigned PERIOD = NUM_GRP * GAP;
  localparam int unsigned PH_W   = $clog2(PERIOD);

  logic [PH_W-1:0] phase;
  logic            run;
  logic            rev;

  stb_phase_ctr #(.PERIOD(PERIOD), .PH_W(PH_W)) i_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_active_i(line_active_i),
    .scan_rev_i   (scan_rev_i),
    .phase_o      (phase),
    .run_o        (run),
    .rev_o        (rev)
  );

  stb_decode #(.NUM_GRP(NUM_GRP), .GAP(GAP), .PERIOD(PERIOD), .PH_W(PH_W)) i_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_i(phase),
    .run_i  (run),
    .rev_i  (rev),
    .stb_o  (stb_o),
    .hck_o  (hck_o)
  );

  p_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(line_active_i) |-> (stb_o == '0 && !hck_o));
  p_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run) |-> (rev ? stb_o[NUM_GRP-1] : stb_o[0]));
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (stb_o == '0 && !hck_o));
endmodule

// File: tb/test_stagger_strobe_gen.sv
module test_stagger_strobe_gen;
  localparam int NG  = 6;
  localparam int GP  = 2;
  localparam int PER = NG * GP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          act = 1'b0;
  logic          rev = 1'b0;
  logic [NG-1:0] stb;
  logic          hck;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  stagger_strobe_gen i_stagger_strobe_gen (
    .clk_i(clk), .rst_ni(rst_n), .line_active_i(act), .scan_rev_i(rev),
    .stb_o(stb), .hck_o(hck)
  );

  task automatic chk(input string req, input logic [NG-1:0] es, input logic eh);
    n_chk++;
    if (stb !== es || hck !== eh) begin
      n_fail++;
      $display("FAIL %s: stb=%b hck=%b expected stb=%b hck=%b at %0t", req, stb, hck, es, eh, $time);
    end
  endtask

  // expected outputs at phase k of a line with direction r
  function automatic logic [NG-1:0] exp_stb(input int k, input logic r);
    int p = k % PER;
    logic [NG-1:0] v = '0;
    if (p % GP == 0) v[r ? (NG - 1 - p / GP) : (p / GP)] = 1'b1;
    return v;
  endfunction

  // one line of len cycles, then gap idle cycles; toggle_at>=0 flips rev mid-line
  task automatic run_line(input int len, input logic r, input int gap, input int toggle_at);
    string tag;
    rev = r;
    act = 1'b1;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      tag = (k == 0) ? "R7" : (toggle_at >= 0 && k > toggle_at) ? "R8" :
            (r ? "R4/R5/R9" : "R3/R5/R9");
      chk(tag, exp_stb(k, r), (k % PER) < PER / 2);
      if (k == toggle_at) rev = ~rev;
      if (k == len - 1) act = 1'b0;
    end
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      chk("R6", '0, 1'b0);
    end
  endtask

  initial begin
    // R1: reset holds outputs low even with qualifier high
    @(negedge clk); act = 1'b1; rev = 1'b1;
    for (int i = 0; i < 4; i++) begin @(negedge clk); chk("R1", '0, 1'b0); end
    act = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); chk("R6", '0, 1'b0);
    run_line(3 * PER, 1'b0, 3, -1);
    run_line(3 * PER, 1'b1, 2, -1);
    for (int len = 1; len <= PER + 3; len++) begin
      run_line(len, len[0], 1, -1);
    end
    run_line(2 * PER + 5, 1'b0, 1, 7);   // R8: mid-line toggle ignored
    run_line(2 * PER + 5, 1'b1, 2, 3);   // R8
    run_line(PER, 1'b1, 1, -1);          // R8: new direction taken at line start
    run_line(5 * PER + 1, 1'b0, 4, -1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: expected completion, got timeout");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule